// File: doc/BRIEF.md
# Ping-Pong Dual Byte Buffer

This block holds two equal byte FIFOs, called banks, that take turns between a 16-bit host port and a byte-wide transfer-engine port. A select bit decides which bank the host sees; the other bank is wired to the engine. While the engine moves one bank's contents on the bus, the host fills or drains the other bank. A one-cycle flip command then swaps the two banks. Neither bank loses data when they swap, because only the routing changes.

The host moves two bytes per access in little-endian order. An odd byte count ends with one partial word. The engine side has a byte-wide pop stream and a byte-wide push stream, each with a valid/ready handshake. Both banks report empty and full status. A sticky error bit records host accesses that were refused.

Top module: `pingpong_byte_buffer`

## Requirements
- R1: After a synchronous active-low reset, both banks are empty, `bank_sel` is 0 (bank 0 faces the host) and `host_err` is 0.
- R2: A host write with `host_wr_two`=1 stores `host_wdata[7:0]` first and `host_wdata[15:8]` second. The engine pops them in that order once the bank has been flipped to the engine side.
- R3: A host write with `host_wr_two`=0 stores only `host_wdata[7:0]`. It adds exactly one byte.
- R4: `host_rdata[7:0]` shows the oldest byte of the host bank and `host_rdata[15:8]` the next one. When only one byte is held, bits 15:8 read 0 and `host_rd` removes that single byte. Otherwise `host_rd` removes two bytes.
- R5: Each bank holds DEPTH bytes (default 512). `host_full` rises once the host has written exactly DEPTH bytes, and `alt_full` reports the same condition for the engine bank.
- R6: A host write that needs more room than is left is ignored and sets the sticky `host_err`. Only reset clears `host_err`.
- R7: A host read of an empty host bank is ignored, sets `host_err` and shows `host_rdata` as 0.
- R8: A `flip` pulse toggles `bank_sel` at the next clock edge. After the flip the bank that faced the host faces the engine, and the reverse, with contents and order intact.
- R9: `eng_out_valid` is high exactly when the engine bank is not empty. `eng_out_data` is its oldest byte, and the byte is removed on a cycle with both valid and ready high.
- R10: `eng_in_ready` is high exactly when the engine bank is not full. A byte offered with `eng_in_valid` and ready high is appended, and the host later reads it in arrival order.
- R11: A host or engine access in the same cycle as `flip` acts on the banks as routed before the flip.
- R12: `host_empty` and `alt_empty` report emptiness of the host bank and the engine bank separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_wr_two | input | 1 | 1: write both bytes, 0: low byte only |
| host_wdata | input | 16 | Host write word, first byte in bits 7:0 |
| host_rd | input | 1 | Host read strobe (pops up to two bytes) |
| host_rdata | output | 16 | Head word of the host bank |
| flip | input | 1 | Swap banks at the next edge |
| bank_sel | output | 1 | Index of the bank facing the host |
| host_empty | output | 1 | Host bank is empty |
| host_full | output | 1 | Host bank is full |
| alt_empty | output | 1 | Engine bank is empty |
| alt_full | output | 1 | Engine bank is full |
| host_err | output | 1 | Sticky refused-access flag |
| eng_out_valid | output | 1 | Engine pop stream has a byte |
| eng_out_ready | input | 1 | Engine takes the byte |
| eng_out_data | output | 8 | Oldest byte of the engine bank |
| eng_in_valid | input | 1 | Engine offers a byte |
| eng_in_ready | output | 1 | Engine bank has room |
| eng_in_data | input | 8 | Byte pushed by the engine |

## Verification
The sensitive coincidence is a `flip` in the same cycle as a host write or read and engine pops or pushes. Each access must land in the bank routed before the swap. The bench provokes this with directed cases and with random flips at high probability among busy traffic. A bench reference model of two byte arrays, with its own select, judges each case: after every edge the model predicts the status flags, the head bytes and `bank_sel`, and any access that went to the wrong bank shows up as a mismatch.

// File: rtl/pp_pkg.sv
// Shared types for the ping-pong byte buffer.
// Assumes: a bank moves at most two bytes per cycle on each of its two sides.
package pp_pkg;
    // Number of bytes moved by one side in one cycle (0, 1 or 2).
    typedef logic [1:0] xfer_n_t;

    localparam xfer_n_t XFER_NONE = 2'd0;
    localparam xfer_n_t XFER_ONE  = 2'd1;
    localparam xfer_n_t XFER_TWO  = 2'd2;
endpackage

// File: rtl/pp_bank.sv
// One byte FIFO bank with a two-byte-wide push and pop.
// Does: stores bytes in ring order and exposes the two oldest bytes.
// Assumes: the caller never pushes past DEPTH or pops past the count (DEPTH >= 2).
module pp_bank
    import pp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  xfer_n_t       push_n,
    input  logic [15:0]   push_data,
    input  xfer_n_t       pop_n,
    output logic [15:0]   head_data,
    output logic [CW-1:0] count
);
    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [AW-1:0] wptr_p1;
    logic [AW-1:0] rptr_p1;

    // Ring index advance by k, wrapping at DEPTH.
    function automatic logic [AW-1:0] ring_add(input logic [AW-1:0] p, input xfer_n_t k);
        logic [AW:0] s;
        s = {1'b0, p} + (AW+1)'(k);
        if (s >= (AW+1)'(DEPTH)) s = s - (AW+1)'(DEPTH);
        return s[AW-1:0];
    endfunction

    // Neighbour indices for the second byte of a word.
    always_comb begin
        wptr_p1 = ring_add(wptr, XFER_ONE);
        rptr_p1 = ring_add(rptr, XFER_ONE);
    end

    // Storage write: the low byte first, the high byte after it.
    always_ff @(posedge clk) begin
        if (push_n != XFER_NONE) mem[wptr] <= push_data[7:0];
        if (push_n == XFER_TWO)  mem[wptr_p1] <= push_data[15:8];
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= ring_add(wptr, push_n);
            rptr  <= ring_add(rptr, pop_n);
            count <= count + CW'(push_n) - CW'(pop_n);
        end
    end

    // Oldest two bytes, oldest in the low half.
    assign head_data = {mem[rptr_p1], mem[rptr]};
endmodule

// File: rtl/pp_host_port.sv
// Host-side access control for the bank currently facing the host.
// Does: decides how many bytes a host write/read moves, formats read data,
// and keeps the sticky error flag for refused accesses.
// Assumes: count and head_data belong to the bank routed to the host this cycle.
module pp_host_port
    import pp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_wr_two,
    input  logic          host_rd,
    input  logic [CW-1:0] count,
    input  logic [15:0]   head_data,
    output xfer_n_t       push_n,
    output xfer_n_t       pop_n,
    output logic [15:0]   host_rdata,
    output logic          host_err
);
    xfer_n_t want_n;
    logic    wr_fits;
    logic    wr_refused;
    logic    rd_refused;

    // Write size and room check against the current occupancy.
    always_comb begin
        want_n     = host_wr_two ? XFER_TWO : XFER_ONE;
        wr_fits    = (count <= CW'(DEPTH) - CW'(want_n));
        wr_refused = host_wr && !wr_fits;
        rd_refused = host_rd && (count == '0);
        push_n     = (host_wr && wr_fits) ? want_n : XFER_NONE;
    end

    // Read size: two bytes if available, otherwise whatever is left.
    always_comb begin
        if (!host_rd || count == '0) pop_n = XFER_NONE;
        else if (count == CW'(1))    pop_n = XFER_ONE;
        else                         pop_n = XFER_TWO;
    end

    // Read word: missing bytes read as zero.
    always_comb begin
        if (count == '0)          host_rdata = 16'h0000;
        else if (count == CW'(1)) host_rdata = {8'h00, head_data[7:0]};
        else                      host_rdata = head_data;
    end

    // Sticky error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) host_err <= 1'b0;
        else if (wr_refused || rd_refused) host_err <= 1'b1;
    end
endmodule

// File: rtl/pp_engine_port.sv
// Engine-side byte streams for the bank facing the transfer engine.
// Does: valid/ready handshakes for the pop and push streams.
// Assumes: count belongs to the bank routed to the engine this cycle.
module pp_engine_port
    import pp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          eng_out_ready,
    input  logic          eng_in_valid,
    input  logic [CW-1:0] count,
    output logic          eng_out_valid,
    output logic          eng_in_ready,
    output xfer_n_t       push_n,
    output xfer_n_t       pop_n
);
    // Handshake outputs and byte moves for this cycle.
    always_comb begin
        eng_out_valid = (count != '0);
        eng_in_ready  = (count != CW'(DEPTH));
        pop_n         = (eng_out_valid && eng_out_ready) ? XFER_ONE : XFER_NONE;
        push_n        = (eng_in_valid && eng_in_ready) ? XFER_ONE : XFER_NONE;
    end
endmodule

// File: rtl/pingpong_byte_buffer.sv
// Ping-pong dual byte buffer between a 16-bit host port and a byte-wide engine.
// Does: routes one bank to the host and the other to the engine, swapping on flip.
// Assumes: flip is a single-cycle request; accesses in the flip cycle use the old routing.
module pingpong_byte_buffer
    import pp_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_wr_two,
    input  logic [15:0] host_wdata,
    input  logic        host_rd,
    output logic [15:0] host_rdata,
    input  logic        flip,
    output logic        bank_sel,
    output logic        host_empty,
    output logic        host_full,
    output logic        alt_empty,
    output logic        alt_full,
    output logic        host_err,
    output logic        eng_out_valid,
    input  logic        eng_out_ready,
    output logic [7:0]  eng_out_data,
    input  logic        eng_in_valid,
    output logic        eng_in_ready,
    input  logic [7:0]  eng_in_data
);
    localparam int NBANK = 2;

    logic [NBANK-1:0][CW-1:0] bank_count;
    logic [NBANK-1:0][15:0]   bank_head;
    xfer_n_t [NBANK-1:0]      bank_push;
    xfer_n_t [NBANK-1:0]      bank_pop;
    logic [NBANK-1:0][15:0]   bank_wdata;

    logic [CW-1:0] host_count;
    logic [CW-1:0] eng_count;
    logic [15:0]   host_head;
    logic [15:0]   eng_head;
    xfer_n_t       h_push, h_pop, e_push, e_pop;

    // Select register: toggles one edge after a flip request.
    always_ff @(posedge clk) begin
        if (!rst_n) bank_sel <= 1'b0;
        else if (flip) bank_sel <= ~bank_sel;
    end

    // Per-side views of the routed banks.
    always_comb begin
        host_count = bank_sel ? bank_count[1] : bank_count[0];
        eng_count  = bank_sel ? bank_count[0] : bank_count[1];
        host_head  = bank_sel ? bank_head[1]  : bank_head[0];
        eng_head   = bank_sel ? bank_head[0]  : bank_head[1];
    end

    pp_host_port #(.DEPTH(DEPTH)) u_host (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_wr_two (host_wr_two),
        .host_rd     (host_rd),
        .count       (host_count),
        .head_data   (host_head),
        .push_n      (h_push),
        .pop_n       (h_pop),
        .host_rdata  (host_rdata),
        .host_err    (host_err)
    );

    pp_engine_port #(.DEPTH(DEPTH)) u_eng (
        .eng_out_ready (eng_out_ready),
        .eng_in_valid  (eng_in_valid),
        .count         (eng_count),
        .eng_out_valid (eng_out_valid),
        .eng_in_ready  (eng_in_ready),
        .push_n        (e_push),
        .pop_n         (e_pop)
    );

    // Cross-connect: the selected bank gets host traffic, the other engine traffic.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic to_host;
        assign to_host       = (bank_sel == 1'(b));
        assign bank_push[b]  = to_host ? h_push : e_push;
        assign bank_pop[b]   = to_host ? h_pop  : e_pop;
        assign bank_wdata[b] = to_host ? host_wdata : {8'h00, eng_in_data};

        pp_bank #(.DEPTH(DEPTH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_n    (bank_push[b]),
            .push_data (bank_wdata[b]),
            .pop_n     (bank_pop[b]),
            .head_data (bank_head[b]),
            .count     (bank_count[b])
        );
    end

    // Status outputs.
    always_comb begin
        host_empty   = (host_count == '0);
        host_full    = (host_count == CW'(DEPTH));
        alt_empty    = (eng_count == '0);
        alt_full     = (eng_count == CW'(DEPTH));
        eng_out_data = eng_head[7:0];
    end
endmodule

// File: rtl/pingpong_byte_buffer_chk.sv
// Port-level checker for the ping-pong byte buffer, bound to the top module.
// Assumes: the synchronous active-low reset is low at time zero.
module pingpong_byte_buffer_chk (
    input logic clk,
    input logic rst_n,
    input logic host_wr,
    input logic host_wr_two,
    input logic host_rd,
    input logic flip,
    input logic bank_sel,
    input logic host_empty,
    input logic host_full,
    input logic alt_empty,
    input logic alt_full,
    input logic host_err,
    input logic eng_out_valid,
    input logic eng_out_ready,
    input logic eng_in_valid,
    input logic eng_in_ready
);
    // Right after reset release, everything is in its initial state.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (host_empty && alt_empty && !bank_sel && !host_err));

    // A flip toggles the select at the next edge.
    assert_flip_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> (bank_sel != $past(bank_sel)));

    // Without a flip the select holds.
    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !flip |=> $stable(bank_sel));

    // A quiet flip swaps the empty indications.
    assert_flip_swap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && !host_wr && !host_rd && !eng_in_valid && !eng_out_ready)
        |=> (host_empty == $past(alt_empty)) && (alt_empty == $past(host_empty)));

    // Writing into a full host bank raises the error.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_full) |=> host_err);

    // The error flag is sticky.
    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_err |=> host_err);

    // Reading an empty host bank raises the error.
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_empty) |=> host_err);

    // Full and empty never coincide on the host bank.
    assert_status_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_full && host_empty));

    // The engine is offered data only from a non-empty bank.
    assert_out_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_out_valid |-> !alt_empty);

    // The engine is never invited to push into a full bank.
    assert_in_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alt_full |-> !eng_in_ready);

    // Empty status of the engine bank is reported on its own (R12).
    assert_alt_empty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        alt_empty |-> !eng_out_valid);
endmodule

bind pingpong_byte_buffer pingpong_byte_buffer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr       (host_wr),
    .host_wr_two   (host_wr_two),
    .host_rd       (host_rd),
    .flip          (flip),
    .bank_sel      (bank_sel),
    .host_empty    (host_empty),
    .host_full     (host_full),
    .alt_empty     (alt_empty),
    .alt_full      (alt_full),
    .host_err      (host_err),
    .eng_out_valid (eng_out_valid),
    .eng_out_ready (eng_out_ready),
    .eng_in_valid  (eng_in_valid),
    .eng_in_ready  (eng_in_ready)
);

// File: tb/pingpong_byte_buffer_tb.sv
`timescale 1ns/1ps
module pingpong_byte_buffer_tb;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_wr_two = 0, host_rd = 0, flip = 0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        bank_sel, host_empty, host_full, alt_empty, alt_full, host_err;
    logic        eng_out_valid, eng_out_ready = 0, eng_in_valid = 0, eng_in_ready;
    logic [7:0]  eng_out_data, eng_in_data = '0;

    always #2.5 clk = ~clk;

    pingpong_byte_buffer #(.DEPTH(D)) u_dut (.*);

    int n_total = 0;
    int n_fail  = 0;

    // Reference model: two byte rings, select and sticky error.
    logic [7:0] mmem [2][D];
    int  mrp [2];
    int  mcnt [2];
    bit  msel, merr;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata(input int h);
        if (mcnt[h] == 0) return 16'h0;
        if (mcnt[h] == 1) return {8'h00, mmem[h][mrp[h]]};
        return {mmem[h][(mrp[h] + 1) % D], mmem[h][mrp[h]]};
    endfunction

    task automatic model_reset();
        mrp = '{0, 0}; mcnt = '{0, 0}; msel = 0; merr = 0;
    endtask

    // Compare every output with the model (sampled mid-cycle).
    task automatic check_outputs();
        int h = msel ? 1 : 0;
        int a = 1 - h;
        chk(bank_sel == msel, "R8 bank_sel", bank_sel, msel);
        chk(host_rdata == exp_rdata(h), "R4 host_rdata", host_rdata, exp_rdata(h));
        chk(host_empty == (mcnt[h] == 0), "R12 host_empty", host_empty, mcnt[h] == 0);
        chk(alt_empty == (mcnt[a] == 0), "R12 alt_empty", alt_empty, mcnt[a] == 0);
        chk(host_full == (mcnt[h] == D), "R5 host_full", host_full, mcnt[h] == D);
        chk(alt_full == (mcnt[a] == D), "R5 alt_full", alt_full, mcnt[a] == D);
        chk(host_err == merr, "R6 host_err", host_err, merr);
        chk(eng_out_valid == (mcnt[a] != 0), "R9 eng_out_valid", eng_out_valid, mcnt[a] != 0);
        if (mcnt[a] != 0)
            chk(eng_out_data == mmem[a][mrp[a]], "R9 eng_out_data", eng_out_data, mmem[a][mrp[a]]);
        chk(eng_in_ready == (mcnt[a] != D), "R10 eng_in_ready", eng_in_ready, mcnt[a] != D);
    endtask

    // Advance the model by one edge with the applied inputs (pre-flip routing, R11).
    task automatic model_step();
        int h = msel ? 1 : 0;
        int a = 1 - h;
        int wn = host_wr_two ? 2 : 1;
        int hw = 0, hr = 0, ew = 0, er = 0;
        if (!rst_n) begin model_reset(); return; end
        if (host_wr) begin
            if (mcnt[h] + wn <= D) hw = wn; else merr = 1;
        end
        if (host_rd) begin
            if (mcnt[h] == 0) merr = 1; else hr = (mcnt[h] >= 2) ? 2 : 1;
        end
        if (eng_out_ready && mcnt[a] != 0) er = 1;
        if (eng_in_valid && mcnt[a] != D) ew = 1;
        if (hw >= 1) mmem[h][(mrp[h] + mcnt[h]) % D] = host_wdata[7:0];
        if (hw == 2) mmem[h][(mrp[h] + mcnt[h] + 1) % D] = host_wdata[15:8];
        if (ew == 1) mmem[a][(mrp[a] + mcnt[a]) % D] = eng_in_data;
        mrp[h] = (mrp[h] + hr) % D; mcnt[h] += hw - hr;
        mrp[a] = (mrp[a] + er) % D; mcnt[a] += ew - er;
        if (flip) msel = !msel;
    endtask

    // One cycle: check mid-cycle, take the edge, update the model, return to negedge.
    task automatic tick();
        #1 check_outputs();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        host_wr = 0; host_rd = 0; flip = 0; eng_out_ready = 0; eng_in_valid = 0;
    endtask

    task automatic do_reset();
        idle(); rst_n = 0;
        repeat (2) tick();
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();
        #1;
        chk(bank_sel == 0 && host_empty && alt_empty && !host_err, "R1 reset state",
            {bank_sel, host_empty, alt_empty, host_err}, 4'b0110);
        tick();

        // R2: word order on the engine side.
        host_wr = 1; host_wr_two = 1; host_wdata = 16'h3412; tick();
        idle(); flip = 1; tick(); idle();
        #1 chk(eng_out_data == 8'h12, "R2 first byte", eng_out_data, 8'h12);
        eng_out_ready = 1; tick();
        #1 chk(eng_out_data == 8'h34, "R2 second byte", eng_out_data, 8'h34);
        tick(); idle();
        #1 chk(!eng_out_valid, "R9 drained", eng_out_valid, 0);

        // R3: partial word, then R4 single-byte read.
        host_wr = 1; host_wr_two = 0; host_wdata = 16'hABCD; tick(); idle();
        #1 chk(host_rdata == 16'h00CD, "R3 partial word", host_rdata, 16'h00CD);
        host_rd = 1; tick(); idle();
        #1 chk(host_empty, "R4 single byte popped", host_empty, 1);

        // R10: engine pushes reach the host in order after a flip.
        eng_in_valid = 1; eng_in_data = 8'h5A; tick();
        eng_in_data = 8'hA5; tick(); idle();
        flip = 1; tick(); idle();
        #1 chk(host_rdata == 16'hA55A, "R10 engine data to host", host_rdata, 16'hA55A);
        host_rd = 1; tick(); idle();

        // R5/R6: fill exactly, then overflow.
        for (int i = 0; i < D / 2; i++) begin
            host_wr = 1; host_wr_two = 1; host_wdata = 16'(i * 257 + 16'h0100); tick();
        end
        idle();
        #1 chk(host_full && !host_err, "R5 full after DEPTH bytes", {host_full, host_err}, 2'b10);
        host_wr = 1; host_wr_two = 0; host_wdata = 16'hEEEE; tick(); idle();
        #1 chk(host_err && host_rdata == 16'h0100, "R6 overflow ignored", {host_err, host_rdata}, {1'b1, 16'h0100});
        tick();

        // R7: empty read.
        do_reset();
        host_rd = 1; tick(); idle();
        #1 chk(host_err && host_rdata == 16'h0, "R7 empty read", {host_err, host_rdata}, {1'b1, 16'h0});

        // R11: write in the flip cycle lands in the pre-flip host bank.
        do_reset();
        host_wr = 1; host_wr_two = 1; host_wdata = 16'hC3B2; flip = 1; tick(); idle();
        #1 chk(host_empty && !alt_empty && eng_out_data == 8'hB2, "R11 write with flip",
               {host_empty, alt_empty, eng_out_data}, {2'b10, 8'hB2});
        tick();

        // Random traffic with fixed seed and shifting bias.
        do_reset();
        void'($urandom(32'h1234));
        for (int c = 0; c < 4000; c++) begin
            int bias = (c / 250) % 3;
            host_wr = ($urandom % 4) < (bias == 0 ? 3 : 1);
            host_wr_two = $urandom % 2;
            host_wdata = 16'($urandom);
            host_rd = ($urandom % 4) < (bias == 1 ? 3 : 1);
            flip = ($urandom % 16) < (bias == 2 ? 6 : 1);
            eng_out_ready = $urandom % 2;
            eng_in_valid = $urandom % 2;
            eng_in_data = 8'($urandom);
            tick();
        end
        idle();
        tick();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule